// File: doc/BRIEF.md
# Shadowed Timebase Counter Unit

This block is the time base of a general-purpose timer. A programmable prescaler divides the clock by its value plus one. Each prescaler tick advances a main counter. The counter can count up or down in edge-aligned form, or run up and then down in three center-aligned forms. The prescaler value and the reload value each have a preload register and an active copy. This lets software stage new values that take effect at a well-defined point.

An update event is raised when the counter passes a period boundary, and optionally when a software request or a slave trigger arrives. The update event moves the staged values into the active copies. It also sets a sticky flag and can stop the counter in single-pulse operation. Configuration uses plain write strobes: one 8-bit control word, a prescaler word, a reload word and a direct counter load.

Top module: `tbase_unit`

## Requirements
- R1: After reset, the counter value is 0, the update pulse and the update flag are 0, and all control bits are 0, so the counter is disabled.
- R2: The control word bits are: enable = bit 0, update disable = bit 1, update source = bit 2, single-pulse = bit 3, direction = bit 4 (1 = down), alignment = bits 6:5, reload shadow enable = bit 7. In edge-aligned up mode (alignment 0, direction 0), the counter steps 0,1,...,ARR on each prescaler tick, then returns to 0 and raises an update event.
- R3: One prescaler tick occurs every PSC+1 clocks. A prescaler write with `psc_now`=1 takes effect at once. With `psc_now`=0, the new value takes effect only after the next update event.
- R4: In edge-aligned down mode (alignment 0, direction 1), the counter steps from ARR down to 0. It then reloads ARR and raises an update event.
- R5: For alignment 1, 2 or 3, the counter runs 0 up to ARR and back down to 0, with an update event at each turn. In these modes the written direction bit is ignored, and `dir_stat` reads 1 only while the counter is counting down.
- R6: `cmp_gate` controls when compare flags are allowed. It is always 1 in edge-aligned mode and in alignment 3. In alignment 1 it is 1 only while counting down. In alignment 2 it is 1 only while counting up.
- R7: While update disable is set, no update event is raised, the flag is not set and no shadow transfer happens. The counter still wraps or reloads at the boundary.
- R8: With update source 0, a software request or a slave trigger also raises an update event. With update source 1, only counter overflow or underflow raises one.
- R9: A software request or a slave trigger always restarts the counter: to ARR in edge-aligned down mode, otherwise to 0 counting up. It also clears the prescaler count.
- R10: With single-pulse set, the enable bit clears on the update event and the counter then stays still.
- R11: With reload shadow disabled, a reload write takes effect on the next clock. With it enabled, the new value takes effect only after the next update event.
- R12: `upd_evt` is a one-cycle pulse, visible in the same cycle as the new counter value. `upd_flag` is set by it and stays set until `flag_clr`. If both occur in the same cycle, the set wins.
- R13: While the counter is disabled, it holds its value. A counter write loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word |
| psc_we | input | 1 | Prescaler write strobe |
| psc_wdata | input | PSC_W | Prescaler value (ratio minus one) |
| psc_now | input | 1 | 1: prescaler write applies at once; 0: at next update |
| arr_we | input | 1 | Reload value write strobe |
| arr_wdata | input | CNT_W | Reload value |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| sw_upd | input | 1 | Software update request |
| slv_trig | input | 1 | Slave trigger (restart) |
| flag_clr | input | 1 | Clears the update flag |
| cnt_val | output | CNT_W | Current counter value |
| upd_evt | output | 1 | One-cycle update event |
| upd_flag | output | 1 | Sticky update flag |
| dir_stat | output | 1 | Effective count direction, 1 = down |
| cen_stat | output | 1 | Current enable bit |
| cmp_gate | output | 1 | Compare flags permitted in current direction |

## Verification
The bench targets period boundaries.
- A counter that compares against the wrong limit shows a period off by one.
- A prescaler preload that leaks through early shortens the count before the boundary.
- A reload shadow that ignores the enable bit either honours the new limit too soon or never honours it.

In center-aligned forms, the bench checks the turn at ARR and at 0, the pulse at both ends, and the compare gate in each of the three variants. A design that latched the written direction bit would report the wrong phase. The bench also separates the two update sources and the update-disable case: a design that tied the restart to the event would lose the restart or raise a spurious pulse. Single-pulse is checked by confirming that the counter stays still after its one period.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

   typedef enum logic [1:0] {
      ALN_EDGE  = 2'd0,
      ALN_CDOWN = 2'd1,
      ALN_CUP   = 2'd2,
      ALN_CBOTH = 2'd3
   } aln_e;

   typedef struct packed {
      logic arpe;
      aln_e aln;
      logic dir;
      logic spm;
      logic usrc;
      logic udis;
      logic cen;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
   import tbase_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              stop,
   output ctrl_t             ctl
);

   ctrl_t wr;
   ctrl_t nxt;

   always_comb begin
      wr  = ctrl_t'(wdata);
      nxt = ctl;
      if (we) begin
         nxt = wr;
         // direction is status only in center-aligned forms
         if (wr.aln != ALN_EDGE) nxt.dir = ctl.dir;
      end
      if (stop) nxt.cen = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl <= '0;
      else        ctl <= nxt;
   end

endmodule

// File: rtl/tbase_shadow.sv
module tbase_shadow #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psc_we,
   input  logic [PSC_W-1:0] psc_wdata,
   input  logic             psc_now,
   input  logic             arr_we,
   input  logic [CNT_W-1:0] arr_wdata,
   input  logic             arpe,
   input  logic             xfer,
   output logic [PSC_W-1:0] psc_act,
   output logic [CNT_W-1:0] arr_eff,
   output logic [CNT_W-1:0] arr_load
);

   logic [PSC_W-1:0] psc_pre;
   logic [CNT_W-1:0] arr_pre;
   logic [CNT_W-1:0] arr_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_pre <= '0;
         psc_act <= '0;
      end else begin
         if (psc_we) psc_pre <= psc_wdata;
         if (psc_we && psc_now) psc_act <= psc_wdata;
         else if (xfer)         psc_act <= psc_pre;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_pre <= '0;
         arr_act <= '0;
      end else begin
         if (arr_we) arr_pre <= arr_wdata;
         if (xfer)   arr_act <= arr_pre;
      end
   end

   // limit used for comparison in the current cycle
   assign arr_eff  = arpe ? arr_act : arr_pre;
   // value to load into the counter this cycle (after any transfer)
   assign arr_load = (xfer || !arpe) ? arr_pre : arr_act;

endmodule

// File: rtl/tbase_presc.sv
module tbase_presc #(
   parameter int PSC_W = 16,
   localparam int PSC_WL = (PSC_W > 0) ? PSC_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic [PSC_WL-1:0] psc_act,
   output logic              tick
);

   generate
      if (PSC_W == 0) begin : g_nopsc
         assign tick = en;
      end else begin : g_psc
         logic [PSC_W-1:0] pcnt;
         logic             last;

         assign last = (pcnt >= psc_act);
         assign tick = en && last;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pcnt <= '0;
            else if (clr) pcnt <= '0;
            else if (en)  pcnt <= last ? '0 : pcnt + PSC_W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/tbase_count.sv
module tbase_count
   import tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  aln_e             aln,
   input  logic             dir_bit,
   input  logic [CNT_W-1:0] arr_eff,
   input  logic [CNT_W-1:0] arr_load,
   input  logic             reinit,
   input  logic             ld_we,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             phase_dn,
   output logic             wrap
);

   logic at_top;
   logic at_bot;
   logic edge_m;
   logic boundary;

   assign at_top = (cnt >= arr_eff);
   assign at_bot = (cnt == '0);
   assign edge_m = (aln == ALN_EDGE);

   always_comb begin
      if (edge_m) boundary = dir_bit  ? at_bot : at_top;
      else        boundary = phase_dn ? at_bot : at_top;
   end

   assign wrap = tick && !reinit && !ld_we && boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         phase_dn <= 1'b0;
      end else if (reinit) begin
         cnt      <= (edge_m && dir_bit) ? arr_load : '0;
         phase_dn <= 1'b0;
      end else if (ld_we) begin
         cnt <= ld_val;
      end else if (tick) begin
         if (edge_m) begin
            if (dir_bit) cnt <= at_bot ? arr_load : cnt - CNT_W'(1);
            else         cnt <= at_top ? '0 : cnt + CNT_W'(1);
         end else if (phase_dn) begin
            if (at_bot) begin
               cnt      <= (arr_eff == '0) ? '0 : CNT_W'(1);
               phase_dn <= 1'b0;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end else begin
            if (at_top) begin
               cnt      <= at_bot ? '0 : cnt - CNT_W'(1);
               phase_dn <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
   import tbase_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16,
   localparam int PSC_WL = (PSC_W > 0) ? PSC_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   input  logic              psc_we,
   input  logic [PSC_WL-1:0] psc_wdata,
   input  logic              psc_now,
   input  logic              arr_we,
   input  logic [CNT_W-1:0]  arr_wdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              sw_upd,
   input  logic              slv_trig,
   input  logic              flag_clr,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              upd_evt,
   output logic              upd_flag,
   output logic              dir_stat,
   output logic              cen_stat,
   output logic              cmp_gate
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("tbase_unit: CNT_W must be within 2..32");
      end
      if (PSC_W < 0 || PSC_W > 32) begin : g_bad_psc
         $error("tbase_unit: PSC_W must be within 0..32");
      end
      if (CTRL_W != 8) begin : g_bad_ctrl
         $error("tbase_unit: control word must be 8 bits");
      end
   endgenerate

   ctrl_t             ctl;
   logic              reinit;
   logic              wrap;
   logic              upd_now;
   logic              tick;
   logic              phase_dn;
   logic [PSC_WL-1:0] psc_act;
   logic [CNT_W-1:0]  arr_eff;
   logic [CNT_W-1:0]  arr_load;

   assign reinit  = sw_upd || slv_trig;
   assign upd_now = !ctl.udis && (wrap || (!ctl.usrc && reinit));

   tbase_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .stop  (upd_now && ctl.spm),
      .ctl   (ctl)
   );

   tbase_shadow #(.CNT_W(CNT_W), .PSC_W(PSC_WL)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .psc_we    (psc_we),
      .psc_wdata (psc_wdata),
      .psc_now   (psc_now),
      .arr_we    (arr_we),
      .arr_wdata (arr_wdata),
      .arpe      (ctl.arpe),
      .xfer      (upd_now),
      .psc_act   (psc_act),
      .arr_eff   (arr_eff),
      .arr_load  (arr_load)
   );

   tbase_presc #(.PSC_W(PSC_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctl.cen),
      .clr     (reinit),
      .psc_act (psc_act),
      .tick    (tick)
   );

   tbase_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .aln      (ctl.aln),
      .dir_bit  (ctl.dir),
      .arr_eff  (arr_eff),
      .arr_load (arr_load),
      .reinit   (reinit),
      .ld_we    (cnt_we),
      .ld_val   (cnt_wdata),
      .cnt      (cnt_val),
      .phase_dn (phase_dn),
      .wrap     (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_evt  <= 1'b0;
         upd_flag <= 1'b0;
      end else begin
         upd_evt <= upd_now;
         if (upd_now)       upd_flag <= 1'b1;
         else if (flag_clr) upd_flag <= 1'b0;
      end
   end

   assign dir_stat = (ctl.aln == ALN_EDGE) ? ctl.dir : phase_dn;
   assign cen_stat = ctl.cen;

   always_comb begin
      unique case (ctl.aln)
         ALN_CDOWN: cmp_gate = phase_dn;
         ALN_CUP:   cmp_gate = !phase_dn;
         default:   cmp_gate = 1'b1;
      endcase
   end

endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             upd_evt,
   input logic             upd_flag,
   input logic             flag_clr,
   input logic             upd_now,
   input logic             udis,
   input logic             spm,
   input logic             cen,
   input logic             sw_upd,
   input logic             slv_trig,
   input logic             cnt_we,
   input logic [CNT_W-1:0] cnt_val
);

   AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |-> upd_flag);  // R12

   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !upd_now) |=> !upd_flag);  // R12

   AST_UDIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      udis |=> !upd_evt);  // R7

   AST_SPM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (spm && upd_now) |=> !cen);  // R10

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen && !sw_upd && !slv_trig && !cnt_we) |=> $stable(cnt_val));  // R13

endmodule

bind tbase_unit tbase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .upd_evt  (upd_evt),
   .upd_flag (upd_flag),
   .flag_clr (flag_clr),
   .upd_now  (upd_now),
   .udis     (ctl.udis),
   .spm      (ctl.spm),
   .cen      (ctl.cen),
   .sw_upd   (sw_upd),
   .slv_trig (slv_trig),
   .cnt_we   (cnt_we),
   .cnt_val  (cnt_val)
);

// File: tb/tbase_unit_tb.sv
`timescale 1ns/1ps
module tbase_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic        psc_we = 1'b0;
   logic [15:0] psc_wdata = '0;
   logic        psc_now = 1'b0;
   logic        arr_we = 1'b0;
   logic [15:0] arr_wdata = '0;
   logic        cnt_we = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic        sw_upd = 1'b0;
   logic        slv_trig = 1'b0;
   logic        flag_clr = 1'b0;
   logic [15:0] cnt_val;
   logic        upd_evt;
   logic        upd_flag;
   logic        dir_stat;
   logic        cen_stat;
   logic        cmp_gate;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tbase_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .psc_we(psc_we), .psc_wdata(psc_wdata), .psc_now(psc_now),
      .arr_we(arr_we), .arr_wdata(arr_wdata), .cnt_we(cnt_we),
      .cnt_wdata(cnt_wdata), .sw_upd(sw_upd), .slv_trig(slv_trig),
      .flag_clr(flag_clr), .cnt_val(cnt_val), .upd_evt(upd_evt),
      .upd_flag(upd_flag), .dir_stat(dir_stat), .cen_stat(cen_stat),
      .cmp_gate(cmp_gate)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic set_arr(input logic [15:0] v);
      arr_we = 1'b1; arr_wdata = v; @(negedge clk); arr_we = 1'b0;
   endtask

   task automatic set_psc(input logic [15:0] v, input logic now);
      psc_we = 1'b1; psc_wdata = v; psc_now = now; @(negedge clk);
      psc_we = 1'b0; psc_now = 1'b0;
   endtask

   task automatic pulse_sw();
      sw_upd = 1'b1; @(negedge clk); sw_upd = 1'b0;
   endtask

   task automatic pulse_slv();
      slv_trig = 1'b1; @(negedge clk); slv_trig = 1'b0;
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic load_cnt(input logic [15:0] v);
      cnt_we = 1'b1; cnt_wdata = v; @(negedge clk); cnt_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cnt", int'(cnt_val), 0);
      chk("R1 evt", int'(upd_evt), 0);
      chk("R1 flag", int'(upd_flag), 0);
      chk("R1 enable", int'(cen_stat), 0);
   endtask

   task automatic t_edge_up();
      set_psc(16'd0, 1'b1);
      set_arr(16'd3);
      set_cfg(8'h04);
      pulse_sw();
      set_cfg(8'h05);
      wait_n(3);
      chk("R2 top value", int'(cnt_val), 3);
      chk("R2 no evt before wrap", int'(upd_evt), 0);
      wait_n(1);
      chk("R2 wrap to 0", int'(cnt_val), 0);
      chk("R12 evt with new count", int'(upd_evt), 1);
      chk("R12 flag set", int'(upd_flag), 1);
      wait_n(1);
      chk("R12 evt one cycle", int'(upd_evt), 0);
      chk("R2 restart count", int'(cnt_val), 1);
   endtask

   task automatic t_hold();
      int c;
      set_cfg(8'h04);
      c = int'(cnt_val);
      wait_n(3);
      chk("R13 held while off", int'(cnt_val), c);
      load_cnt(16'd9);
      chk("R13 counter load", int'(cnt_val), 9);
   endtask

   task automatic t_reinit();
      set_arr(16'd5);
      set_cfg(8'h14);
      pulse_sw();
      chk("R9 down restart to ARR", int'(cnt_val), 5);
      chk("R8 regular source no evt", int'(upd_evt), 0);
      set_cfg(8'h10);
      pulse_sw();
      chk("R8 global sw evt", int'(upd_evt), 1);
      pulse_clr();
      chk("R12 flag cleared", int'(upd_flag), 0);
      pulse_slv();
      chk("R8 global slave evt", int'(upd_evt), 1);
      set_cfg(8'h04);
      pulse_slv();
      chk("R9 up restart to 0", int'(cnt_val), 0);
   endtask

   task automatic t_edge_down();
      set_arr(16'd3);
      set_cfg(8'h14);
      pulse_sw();
      set_cfg(8'h15);
      chk("R4 start at ARR", int'(cnt_val), 3);
      wait_n(3);
      chk("R4 reaches 0", int'(cnt_val), 0);
      chk("R4 no evt at 0", int'(upd_evt), 0);
      wait_n(1);
      chk("R4 reload ARR", int'(cnt_val), 3);
      chk("R4 underflow evt", int'(upd_evt), 1);
   endtask

   task automatic t_psc();
      set_cfg(8'h04);
      set_psc(16'd2, 1'b1);
      set_arr(16'd5);
      pulse_sw();
      set_psc(16'd0, 1'b0);
      set_cfg(8'h05);
      wait_n(3);
      chk("R3 ratio 3 first step", int'(cnt_val), 1);
      wait_n(6);
      chk("R3 preload not early", int'(cnt_val), 3);
      wait_n(9);
      chk("R3 wrap at old ratio", int'(cnt_val), 0);
      chk("R3 evt at wrap", int'(upd_evt), 1);
      wait_n(2);
      chk("R3 new ratio after update", int'(cnt_val), 2);
   endtask

   task automatic t_center(input logic [7:0] aln_bits, input int g2, input int g5);
      set_arr(16'd3);
      set_cfg(aln_bits | 8'h14);
      pulse_sw();
      set_cfg(aln_bits | 8'h15);
      wait_n(2);
      chk("R6 gate counting up", int'(cmp_gate), g2);
      wait_n(1);
      chk("R5 top reached", int'(cnt_val), 3);
      chk("R5 dir bit ignored", int'(dir_stat), 0);
      wait_n(1);
      chk("R5 turn down", int'(cnt_val), 2);
      chk("R5 evt at top", int'(upd_evt), 1);
      chk("R5 dir down", int'(dir_stat), 1);
      wait_n(1);
      chk("R6 gate counting down", int'(cmp_gate), g5);
      wait_n(2);
      chk("R5 turn up", int'(cnt_val), 1);
      chk("R5 evt at bottom", int'(upd_evt), 1);
      chk("R5 dir up", int'(dir_stat), 0);
   endtask

   task automatic t_udis();
      set_cfg(8'h04);
      set_arr(16'd3);
      pulse_sw();
      pulse_clr();
      set_cfg(8'h07);
      wait_n(4);
      chk("R7 reload still happens", int'(cnt_val), 0);
      chk("R7 no evt", int'(upd_evt), 0);
      chk("R7 no flag", int'(upd_flag), 0);
   endtask

   task automatic t_spm();
      set_cfg(8'h04);
      set_arr(16'd2);
      pulse_sw();
      set_cfg(8'h0D);
      wait_n(3);
      chk("R10 evt at end", int'(upd_evt), 1);
      chk("R10 enable cleared", int'(cen_stat), 0);
      wait_n(2);
      chk("R10 counter stopped", int'(cnt_val), 0);
   endtask

   task automatic t_arr_imm();
      set_cfg(8'h04);
      set_arr(16'd7);
      pulse_sw();
      set_cfg(8'h05);
      wait_n(1);
      set_arr(16'd2);
      wait_n(1);
      chk("R11 immediate limit", int'(cnt_val), 0);
      chk("R11 immediate limit evt", int'(upd_evt), 1);
   endtask

   task automatic t_arr_shadow();
      set_cfg(8'h80);
      set_arr(16'd3);
      pulse_sw();
      set_cfg(8'h85);
      wait_n(1);
      set_arr(16'd7);
      wait_n(2);
      chk("R11 old limit kept", int'(cnt_val), 0);
      wait_n(7);
      chk("R11 new limit after update", int'(cnt_val), 7);
      wait_n(1);
      chk("R11 wrap at new limit", int'(cnt_val), 0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      t_reset();
      t_edge_up();
      t_hold();
      t_reinit();
      t_edge_down();
      t_psc();
      t_center(8'h60, 1, 1);
      t_center(8'h20, 0, 1);
      t_center(8'h40, 1, 0);
      t_udis();
      t_spm();
      t_arr_imm();
      t_arr_shadow();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule